// File: doc/BRIEF.md
# Interrupt Edge Capture and Wakeup Controller

This block watches two interrupt pins: a maskable external request and a nonmaskable request. It samples both pins only on the sampling phase of the state clock, passes them through a synchroniser, and turns rising edges into pending bits. The processor's power state (run, idle or powerdown) then decides how each source acts. A source can raise a wake request, present a service request with its vector address, or tell the sequencer to resume at the next instruction with no service.

The CPU sequencer reads the service outputs. It fetches the vector itself and pulses an acknowledge input, which retires the source currently presented. Software reaches a mask register and the pending register through a small one-address-bit register port. In the mask register, one bit enables the maskable source and a separate bit acts as a global enable. Both must be set before the maskable source is serviced. Neither bit gates the wakeup from powerdown.

Top module: `irq_wake_ctrl`

## Requirements
- R1: After reset the mask register (address 0) and the pending register (address 1) read 0, and svcReq, wakeReq, resumeNoSvc and svcVector are all 0.
- R2: The pins are sampled only on clock edges where sampleEn is high. In run or idle mode, the maskable pin is captured when it is high at a sampling edge, and its rising edge sets pending bit 0 on the third sampling edge after the rise, whatever the mask holds. A pulse that covers no sampling edge is ignored.
- R3: In run or idle mode, a rising edge of the nonmaskable pin sets pending bit 1 whatever the mask holds. While that bit is set, svcReq is 1, svcIsNmi is 1 and svcVector is 24'hFF203E.
- R4: A pending maskable source raises svcReq with svcIsNmi 0 and svcVector equal to the EXT_VEC parameter (default 24'hFF2010) only when mask bit 0 (source enable) and mask bit 7 (global enable) are both 1.
- R5: When both sources are pending, the nonmaskable source is presented and pending bit 0 stays set.
- R6: A clock edge with svcAck high clears only the pending bit of the source being presented.
- R7: A write to address 1 loads pending bits [1:0] from regWrData[1:0]: a 1 sets a bit and a 0 clears it. A hardware edge that sets a bit wins over a write or an acknowledge that clears that bit in the same cycle.
- R8: In idle mode (powerMode 2'b01), wakeReq equals svcReq. A masked pending maskable source therefore does not wake the device.
- R9: In powerdown mode (powerMode 2'b10), a high level of the maskable pin at a sampling edge, once synchronised, latches a wake flag whatever the mask and global enable hold. wakeReq follows the flag and stays high until powerMode leaves powerdown.
- R10: In powerdown, if the maskable source is enabled (both bits) when the wake flag is latched, pending bit 0 is set and it is presented for service. If it is not enabled, resumeNoSvc is 1 while the flag is held.
- R11: In powerdown, the nonmaskable pin has no effect: it sets no pending bit and raises no wake. A rise that happens during powerdown and is still held after powerdown ends is not serviced later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | State clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleEn | input | 1 | Sampling phase enable (phase 2) |
| extIrqPin | input | 1 | Maskable external interrupt pin |
| nmiPin | input | 1 | Nonmaskable interrupt pin |
| powerMode | input | 2 | 00 run, 01 idle, 10 powerdown, 11 treated as run |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 mask register, 1 pending register |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| svcAck | input | 1 | Sequencer acknowledges the presented source |
| svcReq | output | 1 | A source requests service |
| svcIsNmi | output | 1 | The presented source is the nonmaskable one |
| svcVector | output | 24 | Vector address of the presented source, 0 when idle |
| wakeReq | output | 1 | Request to leave idle or powerdown |
| resumeNoSvc | output | 1 | Powerdown wake with no service routine |

## Verification
A pending bit can be set by a sampled rising edge in the same cycle that the bit is cleared, either by an acknowledge or by a software write of 0. The bench provokes this by raising the maskable pin and counting sampling edges. It asserts svcAck, or a write of 0 to the pending register, only during the clock cycle that holds the third sampling edge, which is the edge where capture happens. The bit must still read 1 afterwards. A control step shows that the same acknowledge, applied without a coinciding edge, does clear the bit.

// File: rtl/irqw_pkg.sv
package irqw_pkg;
  localparam int PEND_W  = 2;
  localparam int SRC_EXT = 0;
  localparam int SRC_NMI = 1;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'b00,
    MODE_IDLE  = 2'b01,
    MODE_PDOWN = 2'b10,
    MODE_RSVD  = 2'b11
  } pwrMode_e;

  typedef struct packed {
    logic setExt;
    logic setNmi;
    logic ackExt;
    logic ackNmi;
    logic wrMask;
    logic wrPend;
  } dpStrobe_t;
endpackage

// File: rtl/irqw_sync.sv
module irqw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sampleEn,
  input  logic pinIn,
  output logic syncOut
);
  logic [STAGES-1:0] chainQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chainQ <= '0;
    else if (sampleEn) chainQ <= {chainQ[STAGES-2:0], pinIn};
  end

  assign syncOut = chainQ[STAGES-1];
endmodule

// File: rtl/irqw_datapath.sv
module irqw_datapath import irqw_pkg::*; #(
  parameter int DATA_W     = 8,
  parameter int SYNC_STAGES = 2,
  parameter int EXT_EN_BIT = 0,
  parameter int GLB_EN_BIT = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleEn,
  input  logic [PEND_W-1:0] pinBits,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdAddr,
  output logic [PEND_W-1:0] riseBits,
  output logic              extLevel,
  output logic              extSvcEn,
  output logic [PEND_W-1:0] pendBits,
  output logic [DATA_W-1:0] rdData
);
  logic [PEND_W-1:0] syncBits;
  logic [PEND_W-1:0] prevQ;
  logic [PEND_W-1:0] pendQ, pendD;
  logic [DATA_W-1:0] maskQ;

  for (genvar g = 0; g < PEND_W; g++) begin : gSrc
    irqw_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk     (clk),
      .rstN    (rstN),
      .sampleEn(sampleEn),
      .pinIn   (pinBits[g]),
      .syncOut (syncBits[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else if (sampleEn) prevQ <= syncBits;
  end

  assign riseBits = {PEND_W{sampleEn}} & syncBits & ~prevQ;
  assign extLevel = syncBits[SRC_EXT];

  always_comb begin
    pendD = pendQ;
    if (strb.wrPend) pendD = wrData[PEND_W-1:0];
    if (strb.ackExt) pendD[SRC_EXT] = 1'b0;
    if (strb.ackNmi) pendD[SRC_NMI] = 1'b0;
    if (strb.setExt) pendD[SRC_EXT] = 1'b1;
    if (strb.setNmi) pendD[SRC_NMI] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
      maskQ <= '0;
    end else begin
      pendQ <= pendD;
      if (strb.wrMask) maskQ <= wrData;
    end
  end

  assign pendBits = pendQ;
  assign extSvcEn = maskQ[EXT_EN_BIT] & maskQ[GLB_EN_BIT];
  assign rdData   = rdAddr ? DATA_W'(pendQ) : maskQ;

  // capture happens only at sampling edges (or by software write)
  assert_capture_on_sample_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendQ[SRC_EXT]) |-> ($past(sampleEn) || $past(strb.wrPend)));

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ackNmi && !strb.setNmi && !strb.wrPend) |=> !pendQ[SRC_NMI]);

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.setExt |=> pendQ[SRC_EXT]);
endmodule

// File: rtl/irqw_control.sv
module irqw_control import irqw_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleEn,
  input  pwrMode_e          modeSel,
  input  logic [PEND_W-1:0] riseBits,
  input  logic              extLevel,
  input  logic              extSvcEn,
  input  logic [PEND_W-1:0] pendBits,
  input  logic              regWr,
  input  logic              regAddr,
  input  logic              svcAck,
  output dpStrobe_t         strb,
  output logic              svcReq,
  output logic              svcIsNmi,
  output logic              wakeReq,
  output logic              resumeNoSvc
);
  logic inPd, inIdle, pdWakeQ, extReady;

  assign inPd   = (modeSel == MODE_PDOWN);
  assign inIdle = (modeSel == MODE_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pdWakeQ <= 1'b0;
    else if (!inPd) pdWakeQ <= 1'b0;
    else if (sampleEn && extLevel) pdWakeQ <= 1'b1;
  end

  assign extReady = pendBits[SRC_EXT] & extSvcEn;
  assign svcIsNmi = pendBits[SRC_NMI];
  assign svcReq   = pendBits[SRC_NMI] | extReady;

  always_comb begin
    strb = '0;
    if (inPd) strb.setExt = sampleEn & extLevel & ~pdWakeQ & extSvcEn;
    else      strb.setExt = riseBits[SRC_EXT];
    strb.setNmi = ~inPd & riseBits[SRC_NMI];
    strb.ackNmi = svcAck & pendBits[SRC_NMI];
    strb.ackExt = svcAck & ~pendBits[SRC_NMI] & extReady;
    strb.wrMask = regWr & ~regAddr;
    strb.wrPend = regWr & regAddr;
  end

  assign wakeReq     = inPd ? pdWakeQ : (inIdle & svcReq);
  assign resumeNoSvc = inPd & pdWakeQ & ~extSvcEn;

  assert_idle_masked_nowake_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inIdle && !pendBits[SRC_NMI] && !extSvcEn) |-> !wakeReq);

  assert_pd_wake_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inPd && pdWakeQ) |=> (!inPd || pdWakeQ));

  assert_resume_implies_wake_R10: assert property (@(posedge clk) disable iff (!rstN)
    resumeNoSvc |-> (wakeReq && !pendBits[SRC_NMI] || wakeReq));
endmodule

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl import irqw_pkg::*; #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int VEC_W       = 24,
  parameter logic [VEC_W-1:0] EXT_VEC = 24'hFF2010,
  parameter logic [VEC_W-1:0] NMI_VEC = 24'hFF203E,
  parameter int EXT_EN_BIT  = 0,
  parameter int GLB_EN_BIT  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleEn,
  input  logic              extIrqPin,
  input  logic              nmiPin,
  input  logic [1:0]        powerMode,
  input  logic              regWr,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              svcAck,
  output logic              svcReq,
  output logic              svcIsNmi,
  output logic [VEC_W-1:0]  svcVector,
  output logic              wakeReq,
  output logic              resumeNoSvc
);
  pwrMode_e          modeSel;
  dpStrobe_t         strb;
  logic [PEND_W-1:0] riseBits, pendBits, pinBits;
  logic              extLevel, extSvcEn;

  assign modeSel = pwrMode_e'(powerMode);
  assign pinBits = {nmiPin, extIrqPin};

  irqw_datapath #(
    .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES),
    .EXT_EN_BIT(EXT_EN_BIT), .GLB_EN_BIT(GLB_EN_BIT)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .pinBits(pinBits),
    .strb(strb), .wrData(regWrData), .rdAddr(regAddr),
    .riseBits(riseBits), .extLevel(extLevel), .extSvcEn(extSvcEn),
    .pendBits(pendBits), .rdData(regRdData)
  );

  irqw_control i_control (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .modeSel(modeSel),
    .riseBits(riseBits), .extLevel(extLevel), .extSvcEn(extSvcEn),
    .pendBits(pendBits), .regWr(regWr), .regAddr(regAddr), .svcAck(svcAck),
    .strb(strb), .svcReq(svcReq), .svcIsNmi(svcIsNmi),
    .wakeReq(wakeReq), .resumeNoSvc(resumeNoSvc)
  );

  assign svcVector = !svcReq ? '0 : (svcIsNmi ? NMI_VEC : EXT_VEC);

  assert_nmi_vector_R3: assert property (@(posedge clk) disable iff (!rstN)
    (svcReq && svcIsNmi) |-> (svcVector == NMI_VEC));

  assert_pd_nmi_ignored_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendBits[SRC_NMI]) |-> ($past(powerMode) != 2'b10 || $past(regWr)));

  assert_nmi_first_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pendBits == 2'b11) |-> svcIsNmi);
endmodule

// File: tb/test_irq_wake_ctrl.sv
module test_irq_wake_ctrl;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, sampleEn, extIrqPin, nmiPin, regWr, regAddr, svcAck;
  logic [1:0]  powerMode;
  logic [7:0]  regWrData, regRdData;
  logic        svcReq, svcIsNmi, wakeReq, resumeNoSvc;
  logic [23:0] svcVector;

  localparam logic [23:0] EXT_V = 24'hFF2010;
  localparam logic [23:0] NMI_V = 24'hFF203E;

  irq_wake_ctrl i_irq_wake_ctrl (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .extIrqPin(extIrqPin),
    .nmiPin(nmiPin), .powerMode(powerMode), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .svcAck(svcAck),
    .svcReq(svcReq), .svcIsNmi(svcIsNmi), .svcVector(svcVector),
    .wakeReq(wakeReq), .resumeNoSvc(resumeNoSvc)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic        ext;
    logic        nmi;
    logic [7:0]  mask;
    logic [1:0]  pend;
    logic        svc;
    logic        isNmi;
    logic        wake;
    logic        res;
    logic [23:0] tag;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b1, 1'b0, 8'h81, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, "R4"},
    '{2'd0, 1'b1, 1'b0, 8'h01, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, "R4"},
    '{2'd0, 1'b1, 1'b0, 8'h00, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, "R2"},
    '{2'd0, 1'b0, 1'b1, 8'h00, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, "R3"},
    '{2'd0, 1'b1, 1'b1, 8'h81, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, "R5"},
    '{2'd1, 1'b1, 1'b0, 8'h81, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, "R8"},
    '{2'd1, 1'b1, 1'b0, 8'h00, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, "R8"},
    '{2'd1, 1'b0, 1'b1, 8'h00, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, "R8"},
    '{2'd2, 1'b1, 1'b0, 8'h81, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, "R10"},
    '{2'd2, 1'b1, 1'b0, 8'h00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, "R9"},
    '{2'd2, 1'b1, 1'b0, 8'h80, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, "R10"},
    '{2'd2, 1'b1, 1'b0, 8'h01, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, "R9"},
    '{2'd2, 1'b0, 1'b1, 8'h81, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, "R11"}
  };

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic en);
    @(negedge clk);
    sampleEn = en;
    @(posedge clk);
    #1;
  endtask

  task automatic periods(input int n);
    for (int i = 0; i < n; i++) begin
      step(1'b0);
      step(1'b1);
    end
  endtask

  task automatic regWrite(input logic a, input logic [7:0] d);
    regWr = 1'b1; regAddr = a; regWrData = d;
    step(1'b0);
    regWr = 1'b0; regWrData = 8'h00;
  endtask

  task automatic readReg(input logic a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic doReset();
    rstN = 1'b0; sampleEn = 1'b0; extIrqPin = 1'b0; nmiPin = 1'b0;
    regWr = 1'b0; regAddr = 1'b0; svcAck = 1'b0; powerMode = 2'b00;
    regWrData = 8'h00;
    step(1'b0);
    step(1'b0);
    rstN = 1'b1;
    step(1'b0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [7:0] d;

    // R1: reset state
    doReset();
    readReg(1'b0, d); chk("R1", "mask", 32'(d), 32'h0);
    readReg(1'b1, d); chk("R1", "pend", 32'(d), 32'h0);
    chk("R1", "svcReq", 32'(svcReq), 32'h0);
    chk("R1", "wakeReq", 32'(wakeReq), 32'h0);
    chk("R1", "resume", 32'(resumeNoSvc), 32'h0);
    chk("R1", "vector", 32'(svcVector), 32'h0);

    // table of mode/pin/mask vectors
    for (int v = 0; v < NV; v++) begin
      string t;
      t = $sformatf("%s", VECS[v].tag);
      doReset();
      regWrite(1'b0, VECS[v].mask);
      powerMode = VECS[v].mode;
      step(1'b0);
      extIrqPin = VECS[v].ext;
      nmiPin    = VECS[v].nmi;
      periods(4);
      readReg(1'b1, d);
      chk(t, "pend", 32'(d), 32'(VECS[v].pend));
      chk(t, "svcReq", 32'(svcReq), 32'(VECS[v].svc));
      chk(t, "wakeReq", 32'(wakeReq), 32'(VECS[v].wake));
      chk(t, "resume", 32'(resumeNoSvc), 32'(VECS[v].res));
      if (VECS[v].svc) begin
        chk(t, "isNmi", 32'(svcIsNmi), 32'(VECS[v].isNmi));
        chk(t, "vector", 32'(svcVector), VECS[v].isNmi ? 32'(NMI_V) : 32'(EXT_V));
      end
      extIrqPin = 1'b0; nmiPin = 1'b0;
    end

    // R2: pulse between sampling edges is missed, one full period is caught
    doReset();
    extIrqPin = 1'b1; step(1'b0); extIrqPin = 1'b0;
    periods(4);
    readReg(1'b1, d); chk("R2", "short pulse pend", 32'(d), 32'h0);
    extIrqPin = 1'b1; step(1'b0); step(1'b1); extIrqPin = 1'b0;
    periods(4);
    readReg(1'b1, d); chk("R2", "one period pend", 32'(d), 32'h1);

    // R5 / R6: priority and acknowledge
    doReset();
    regWrite(1'b0, 8'h81);
    extIrqPin = 1'b1; nmiPin = 1'b1;
    periods(4);
    extIrqPin = 1'b0; nmiPin = 1'b0;
    chk("R5", "isNmi both", 32'(svcIsNmi), 32'h1);
    svcAck = 1'b1; step(1'b0); svcAck = 1'b0;
    readReg(1'b1, d); chk("R6", "pend after ack", 32'(d), 32'h1);
    chk("R5", "ext presented", 32'(svcVector), 32'(EXT_V));
    chk("R5", "isNmi after", 32'(svcIsNmi), 32'h0);
    svcAck = 1'b1; step(1'b0); svcAck = 1'b0;
    readReg(1'b1, d); chk("R6", "pend after 2nd ack", 32'(d), 32'h0);
    chk("R6", "svcReq idle", 32'(svcReq), 32'h0);

    // R7: software writes
    regWrite(1'b1, 8'h02);
    readReg(1'b1, d); chk("R7", "write set", 32'(d), 32'h2);
    chk("R7", "nmi svc", 32'(svcIsNmi & svcReq), 32'h1);
    regWrite(1'b1, 8'h00);
    readReg(1'b1, d); chk("R7", "write clear", 32'(d), 32'h0);

    // R7: edge set collides with acknowledge
    doReset();
    regWrite(1'b0, 8'h81);
    regWrite(1'b1, 8'h01);
    extIrqPin = 1'b1;
    periods(2);
    step(1'b0);
    svcAck = 1'b1; step(1'b1); svcAck = 1'b0;
    readReg(1'b1, d); chk("R7", "set beats ack", 32'(d), 32'h1);
    extIrqPin = 1'b0;
    periods(4);
    svcAck = 1'b1; step(1'b0); svcAck = 1'b0;
    readReg(1'b1, d); chk("R6", "ack alone clears", 32'(d), 32'h0);
    // R7: edge set collides with write of 0
    extIrqPin = 1'b1;
    periods(2);
    step(1'b0);
    regWr = 1'b1; regAddr = 1'b1; regWrData = 8'h00;
    step(1'b1);
    regWr = 1'b0;
    readReg(1'b1, d); chk("R7", "set beats write", 32'(d), 32'h1);
    extIrqPin = 1'b0;

    // R11: nmi rise in powerdown, held past exit
    doReset();
    regWrite(1'b0, 8'h81);
    powerMode = 2'b10; step(1'b0);
    nmiPin = 1'b1;
    periods(4);
    chk("R11", "pd wake", 32'(wakeReq), 32'h0);
    powerMode = 2'b00;
    periods(4);
    readReg(1'b1, d); chk("R11", "no late pend", 32'(d), 32'h0);
    chk("R11", "no late svc", 32'(svcReq), 32'h0);
    nmiPin = 1'b0; periods(4);
    nmiPin = 1'b1; periods(4);
    readReg(1'b1, d); chk("R3", "run nmi pend", 32'(d), 32'h2);
    nmiPin = 1'b0;

    // R9: wake held after pin drops, released on mode exit
    doReset();
    powerMode = 2'b10; step(1'b0);
    extIrqPin = 1'b1; periods(4);
    extIrqPin = 1'b0; periods(4);
    chk("R9", "wake held", 32'(wakeReq), 32'h1);
    chk("R10", "resume held", 32'(resumeNoSvc), 32'h1);
    powerMode = 2'b00; step(1'b0);
    chk("R9", "wake released", 32'(wakeReq), 32'h0);
    chk("R10", "resume released", 32'(resumeNoSvc), 32'h0);

    summary();
  end
endmodule